// File: doc/BRIEF.md
# PLL Divider Chain with Test Observation Mux

This block holds the digital counters that sit around a frequency synthesizer loop, plus the multiplexer that picks what drives a single test pin. Everything runs on one system clock. The crystal, the VCO and the serial programming clock appear only as single-cycle enable strobes, so one strobe stands for one period of that source. From these strobes the block makes a fixed reference prescale by sixteen, a programmable feedback divide by M, a second divide by M on the serial clock, and a programmable output divide by N.

The loader that owns the M, N and test-select values drives them as plain levels. A changed M or N value never cuts a divider period short. Each divider keeps its own copy of the active ratio and reloads it only when it wraps, so the clock it drives shows no runt pulse. The test output is a registered eight-way mux over internal clocks, two constant levels and the serial shift-register tap.

Top module: `synth_div_chain`

## Requirements
- R1: `ref_clk_out` divides `ref_en` strobes by 16. After reset it is low for 8 strobes, then high for 8 strobes, and it changes only in a cycle that follows a strobe.
- R2: `fb_clk_out` is high for exactly one strobe interval out of every M `vco_en` strobes, namely the last interval before the divider wraps. An M value of 0 acts as 1.
- R3: For `n_code` 00, 01 and 10, `out_clk` divides `vco_en` strobes by 2, 4 and 8. Each period is low for its first half and high for its second half.
- R4: For `n_code` 11 (divide by 1), `out_clk` is high for one system clock after each clock edge that samples `vco_en` high, and low otherwise.
- R5: A new `m_val` is taken up only at the strobe that wraps the divider. The period already in progress finishes with the old M.
- R6: A new `n_code` is taken up only at the strobe that completes the current output period. The period already in progress finishes with the old ratio.
- R7: Test code 000 routes `sreg_tap` to `test_out`. Code 001 drives it high and code 101 drives it low.
- R8: Test code 010 routes the divided reference. Code 011 routes a signal that toggles at each feedback wrap. Code 100 routes `out_clk`.
- R9: Test code 110 routes a signal that toggles at each wrap of the serial-clock divide by M. Code 111 routes the output clock divided by 4: it toggles every two completed output periods.
- R10: `test_out` is registered. It shows the selected source and code as they stood one system clock earlier.
- R11: While `rst` is high at a clock edge, all counters clear, the active M and N are loaded from the inputs, and all outputs go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One strobe per crystal period |
| vco_en | input | 1 | One strobe per VCO period |
| ser_en | input | 1 | One strobe per serial clock rising edge |
| sreg_tap | input | 1 | Last stage of the serial shift register |
| m_val | input | 9 | Requested feedback divide value M |
| n_code | input | 2 | Requested output divide code |
| t_code | input | 3 | Test output select |
| ref_clk_out | output | 1 | Reference divided by 16 |
| fb_clk_out | output | 1 | VCO divided by M, narrow high phase |
| out_clk | output | 1 | VCO divided by N |
| test_out | output | 1 | Registered test observation output |

## Verification
A counter that is off by one, or that misses its wrap, shows up at once as a wrong high interval or period on `ref_clk_out`, `fb_clk_out` or `out_clk`, within one divide period of the fault. A ratio copy reloaded at the wrong moment shows up differently. The first output period after an M or N change is then truncated or stretched, so the bench changes ratios partway through periods and compares every cycle. Faults in the halving toggles or the divide-by-4 counter reach the pins only through the test mux, one cycle after the selected source moves. For that reason the bench walks all eight test codes while the dividers run.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int M_W    = 9;
    localparam int NCODE_W = 2;
    localparam int NR_W   = 4;

    typedef enum logic [2:0] {
        TS_TAP    = 3'b000,
        TS_HIGH   = 3'b001,
        TS_REF    = 3'b010,
        TS_FBHALF = 3'b011,
        TS_OUT    = 3'b100,
        TS_LOW    = 3'b101,
        TS_SERM   = 3'b110,
        TS_OUTQ   = 3'b111
    } test_sel_e;

    typedef struct packed {
        logic ref_clk;
        logic fb_half;
        logic out_clk;
        logic out_div4;
        logic ser_half;
    } div_taps_t;

    function automatic logic [NR_W-1:0] n_ratio(input logic [NCODE_W-1:0] code);
        case (code)
            2'b00:   n_ratio = 4'd2;
            2'b01:   n_ratio = 4'd4;
            2'b10:   n_ratio = 4'd8;
            default: n_ratio = 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/sd_fixed_div.sv
module sd_fixed_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic div_out
);
    localparam int W = $clog2(DIV);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (en)
            cnt <= (cnt == W'(DIV - 1)) ? '0 : cnt + W'(1);
    end

    assign div_out = (cnt >= W'(DIV / 2));

    assert_ref_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |-> $stable(div_out));

endmodule

// File: rtl/sd_mod_div.sv
module sd_mod_div #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] ratio,
    output logic         pulse,
    output logic         half
);
    logic [W-1:0] cnt;
    logic [W-1:0] mr;
    logic [W-1:0] eff;
    logic         wrap;

    assign eff  = (ratio == '0) ? W'(1) : ratio;
    assign wrap = (cnt == mr - W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            mr   <= eff;
            half <= 1'b0;
        end else if (en) begin
            if (wrap) begin
                cnt  <= '0;
                mr   <= eff;
                half <= ~half;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end

    assign pulse = wrap;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt < mr);

    assert_m_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (mr != $past(mr))) |-> $past(en && (cnt == mr - W'(1))));

endmodule

// File: rtl/sd_out_div.sv
module sd_out_div
    import synth_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [NCODE_W-1:0] code,
    output logic               out_clk,
    output logic               out_div4
);
    logic [NR_W-1:0] nr;
    logic [2:0]      pc;
    logic            pulse_r;
    logic [1:0]      q4;
    logic            done;

    assign done = ({1'b0, pc} == nr - NR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            nr      <= n_ratio(code);
            pc      <= '0;
            pulse_r <= 1'b0;
            q4      <= '0;
        end else begin
            pulse_r <= en;
            if (en) begin
                if (done) begin
                    pc <= '0;
                    nr <= n_ratio(code);
                    q4 <= q4 + 2'd1;
                end else begin
                    pc <= pc + 3'd1;
                end
            end
        end
    end

    assign out_clk  = (nr == NR_W'(1)) ? pulse_r : ({1'b0, pc} >= (nr >> 1));
    assign out_div4 = q4[1];

    assert_pc_range_R3: assert property (@(posedge clk) disable iff (rst)
        {1'b0, pc} < nr);

    assert_n_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (nr != $past(nr))) |-> $past(en && done));

endmodule

// File: rtl/sd_test_mux.sv
module sd_test_mux
    import synth_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tap,
    input  test_sel_e sel,
    input  div_taps_t taps,
    output logic      test_out
);
    logic pick;

    always_comb begin
        case (sel)
            TS_TAP:    pick = tap;
            TS_HIGH:   pick = 1'b1;
            TS_REF:    pick = taps.ref_clk;
            TS_FBHALF: pick = taps.fb_half;
            TS_OUT:    pick = taps.out_clk;
            TS_LOW:    pick = 1'b0;
            TS_SERM:   pick = taps.ser_half;
            default:   pick = taps.out_div4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            test_out <= 1'b0;
        else
            test_out <= pick;
    end

    assert_test_high_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(sel) == TS_HIGH)) |-> test_out);

    assert_test_low_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(sel) == TS_LOW)) |-> !test_out);

    assert_test_tap_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(sel) == TS_TAP)) |-> (test_out == $past(tap)));

endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
    import synth_div_pkg::*;
#(
    parameter int REF_DIV = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_en,
    input  logic               vco_en,
    input  logic               ser_en,
    input  logic               sreg_tap,
    input  logic [M_W-1:0]     m_val,
    input  logic [NCODE_W-1:0] n_code,
    input  logic [2:0]         t_code,
    output logic               ref_clk_out,
    output logic               fb_clk_out,
    output logic               out_clk,
    output logic               test_out
);
    div_taps_t taps;
    logic      ser_pulse;

    sd_fixed_div #(.DIV(REF_DIV)) u_ref (
        .clk(clk), .rst(rst), .en(ref_en), .div_out(taps.ref_clk)
    );

    sd_mod_div #(.W(M_W)) u_fb (
        .clk(clk), .rst(rst), .en(vco_en), .ratio(m_val),
        .pulse(fb_clk_out), .half(taps.fb_half)
    );

    sd_mod_div #(.W(M_W)) u_ser (
        .clk(clk), .rst(rst), .en(ser_en), .ratio(m_val),
        .pulse(ser_pulse), .half(taps.ser_half)
    );

    sd_out_div u_out (
        .clk(clk), .rst(rst), .en(vco_en), .code(n_code),
        .out_clk(taps.out_clk), .out_div4(taps.out_div4)
    );

    sd_test_mux u_mux (
        .clk(clk), .rst(rst), .tap(sreg_tap), .sel(test_sel_e'(t_code)),
        .taps(taps), .test_out(test_out)
    );

    assign ref_clk_out = taps.ref_clk;
    assign out_clk     = taps.out_clk;

    assert_reset_clear_R11: assert property (@(posedge clk)
        $past(rst) |-> (!ref_clk_out && !test_out && !taps.fb_half && !taps.out_div4));

endmodule

// File: tb/synth_div_chain_test.sv
module synth_div_chain_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b0, vco_en = 1'b0, ser_en = 1'b0, sreg_tap = 1'b0;
    logic [8:0] m_val = 9'd5;
    logic [1:0] n_code = 2'd0;
    logic [2:0] t_code = 3'd0;
    logic       ref_clk_out, fb_clk_out, out_clk, test_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic  e_ref, e_fb, e_out, e_tst;
        string t_ref, t_fb, t_out, t_tst;
    } exp_t;
    exp_t sb[$];

    synth_div_chain uut (
        .clk(clk), .rst(rst), .ref_en(ref_en), .vco_en(vco_en), .ser_en(ser_en),
        .sreg_tap(sreg_tap), .m_val(m_val), .n_code(n_code), .t_code(t_code),
        .ref_clk_out(ref_clk_out), .fb_clk_out(fb_clk_out), .out_clk(out_clk),
        .test_out(test_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state, written from the requirements
    int m_rc, m_mc, m_mr, m_sc, m_sr, m_pc, m_nr, m_q4;
    bit m_fh, m_sh, m_pl, m_tst;

    function automatic int ratio_of(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic bit mo_ref();  return m_rc >= 8; endfunction
    function automatic bit mo_fb();   return m_mc == m_mr - 1; endfunction
    function automatic bit mo_out();  return (m_nr == 1) ? m_pl : (m_pc >= m_nr / 2); endfunction

    task automatic step(input bit r, input bit re, input bit ve, input bit se,
                        input bit tap, input int m, input int n, input int t);
        int  eff;
        bit  pick;
        eff = (m == 0) ? 1 : m;
        case (t)
            0: pick = tap;
            1: pick = 1'b1;
            2: pick = mo_ref();
            3: pick = m_fh;
            4: pick = mo_out();
            5: pick = 1'b0;
            6: pick = m_sh;
            default: pick = m_q4[1];
        endcase
        if (r) begin
            m_rc = 0; m_mc = 0; m_mr = eff; m_fh = 0; m_sc = 0; m_sr = eff; m_sh = 0;
            m_pc = 0; m_nr = ratio_of(n); m_pl = 0; m_q4 = 0; m_tst = 0;
        end else begin
            m_tst = pick;
            if (re) m_rc = (m_rc + 1) % 16;
            if (ve) begin
                if (m_mc == m_mr - 1) begin m_mc = 0; m_mr = eff; m_fh = ~m_fh; end
                else m_mc++;
                if (m_pc == m_nr - 1) begin m_pc = 0; m_nr = ratio_of(n); m_q4 = (m_q4 + 1) % 4; end
                else m_pc++;
            end
            if (se) begin
                if (m_sc == m_sr - 1) begin m_sc = 0; m_sr = eff; m_sh = ~m_sh; end
                else m_sc++;
            end
            m_pl = ve;
        end
    endtask

    task automatic drive(input bit r, input bit re, input bit ve, input bit se,
                         input bit tap, input int m, input int n, input int t);
        exp_t e;
        @(negedge clk);
        rst = r; ref_en = re; vco_en = ve; ser_en = se; sreg_tap = tap;
        m_val = 9'(m); n_code = 2'(n); t_code = 3'(t);
        step(r, re, ve, se, tap, m, n, t);
        e.e_ref = mo_ref(); e.e_fb = mo_fb(); e.e_out = mo_out(); e.e_tst = m_tst;
        if (r) begin
            e.t_ref = "R11"; e.t_fb = "R11"; e.t_out = "R11"; e.t_tst = "R11";
        end else begin
            e.t_ref = "R1";
            e.t_fb  = "R2 R5";
            e.t_out = (m_nr == 1) ? "R4 R6" : "R3 R6";
            case (t)
                0, 1, 5: e.t_tst = "R7 R10";
                2, 3, 4: e.t_tst = "R8 R10";
                default: e.t_tst = "R9 R10";
            endcase
        end
        sb.push_back(e);
    endtask

    task automatic cmp(input logic act, input logic exp, input string tag, input string nm);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // monitor: pops expected items after each edge settles
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(ref_clk_out, e.e_ref, e.t_ref, "ref_clk_out");
            cmp(fb_clk_out,  e.e_fb,  e.t_fb,  "fb_clk_out");
            cmp(out_clk,     e.e_out, e.t_out, "out_clk");
            cmp(test_out,    e.e_tst, e.t_tst, "test_out");
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, 0, 5, 0, 0);
        // R1 R2 R3 R8: steady strobes, observe reference, feedback toggle, output
        for (int i = 0; i < 60; i++)
            drive(0, 1, 1, (i % 3) == 0, i[0], 5, 0, 2 + i / 20);
        // R7 R9 R10: walk all test codes
        for (int t = 0; t < 8; t++)
            for (int i = 0; i < 24; i++)
                drive(0, i[0], 1, (i % 2) == 0, (i % 5) < 2, 3, 1, t);
        // R6 R4: output code changes in the middle of periods
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 37; i++)
                drive(0, 1, (i % 3) != 0, 1, 0, 3, (k + 2) % 4, (i < 20) ? 4 : 7);
        // R5: M changes mid period, including M of 0
        for (int i = 0; i < 30; i++) drive(0, 1, 1, 1, 0, 4, 3, 3);
        for (int i = 0; i < 23; i++) drive(0, 0, 1, 1, 1, 7, 0, 6);
        for (int i = 0; i < 20; i++) drive(0, 1, 1, 1, 0, 0, 0, 3);
        for (int i = 0; i < 21; i++) drive(0, 1, (i % 2) == 0, 1, 0, 2, 2, 6);
        // R11: reset in mid run, then resume
        for (int i = 0; i < 2; i++) drive(1, 1, 1, 1, 1, 6, 1, 1);
        for (int i = 0; i < 30; i++) drive(0, 1, 1, i[0], 1, 6, 1, i % 8);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule